// File: doc/BRIEF.md
# Serial Gain and Power Control Port

This block is the control front end of a variable-gain transmit stage. A host writes 12-bit frames over three wires: a serial clock, a serial data line and an active-low select. Each frame carries a 4-bit register address and a data byte. The power/gain register holds a 2-bit power code and a 6-bit gain code, where the gain code runs from 0 to 63 in unit steps. A second address is a clear command.

Writes land in a shadow copy. The codes that drive the amplifier change only when the transmit-enable input falls. This lets the host reprogram gain during a burst and have the change take effect once the burst ends. For a fixed number of system clock cycles after reset, the block drops every frame. While transmit-enable is low, an output-disable flag is raised.

All three serial inputs and transmit-enable are brought into the system clock domain through two-flop synchronizers, and their edges are detected there.

The frame receiver has three states. `ST_IDLE` waits for select to fall and then goes to `ST_SHIFT`. `ST_SHIFT` samples one data bit on every serial-clock rise and goes to `ST_CHECK` when select rises. `ST_CHECK` issues a frame strobe if exactly 12 bits were counted, and always returns to `ST_IDLE` on the next cycle.

Top module: `ser_ctl_regs`

## Requirements
- R1: A frame is 12 bits, sent most significant bit first and sampled on serial-clock rises. Bits 11:8 are the address and bits 7:0 are the data. A write to address 4'h0 stores data[7:6] as the power code and data[5:0] as the gain code in the shadow register.
- R2: `gain_out` and `pwr_out` keep their values until transmit-enable falls from high to low. At that fall they take the current shadow contents.
- R3: When several frames are written before a commit, the commit delivers the most recent one.
- R4: A frame whose select-low window holds any number of serial-clock rises other than 12 (for example 11 or 13) changes neither the shadow nor the active codes.
- R5: A frame to any address other than 4'h0 or 4'h1 changes neither the shadow nor the active codes.
- R6: A frame to address 4'h1 clears the shadow and active codes to zero at once, without a commit.
- R7: After reset, `lock_busy` stays high for LOCK_CYCLES system clock cycles and then stays low. Any frame that completes while it is high is dropped.
- R8: `out_off` is high while transmit-enable is low and low while it is high, after a two-cycle synchronizer delay.
- R9: Reset drives `gain_out` and `pwr_out` to zero, and drives `lock_busy` and `out_off` high.
- R10: Serial-clock rises while select is high are ignored. They do not disturb the bit count of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, data sampled on its rise |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Active-low frame select |
| tx_on | input | 1 | Transmit enable; its falling edge commits the shadow codes |
| gain_out | output | 6 | Active gain code |
| pwr_out | output | 2 | Active power code |
| lock_busy | output | 1 | High during the power-up lockout |
| out_off | output | 1 | Output-disable flag, high while transmit is disabled |

## Verification
A receiver left in the wrong state, or a bit counter that is off by one, shows up at the ports as a dropped frame or a byte shifted by one bit. This becomes visible on the first commit after the frame, within a few cycles of the transmit-enable fall. A shadow register that leaks straight to the outputs shows a changed code before any commit, so the active codes are checked both between the write and the commit and again after the commit. A faulty lockout counter either lets an early frame through, which shows on the next commit, or never releases, which leaves every later check at zero.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int GAIN_W     = 6;
    localparam int PWR_W      = DATA_W - GAIN_W;

    localparam logic [ADDR_W-1:0] ADDR_PG   = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 4'h1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CHECK = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic [PWR_W-1:0]  pwr;
        logic [GAIN_W-1:0] gain;
    } pg_word_t;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
            end
        end
        assign sync_out[i] = sync_q;
    end
endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx
    import ser_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              dat_s,
    input  logic              sel_n_s,
    output logic              frame_vld,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data
);
    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_t              state_q, state_d;
    logic                   sclk_q, sel_n_q;
    logic                   sclk_rise, sel_fall, sel_rise;
    logic [FRAME_BITS-1:0]  shift_q;
    logic [CNT_W-1:0]       cnt_q;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sel_fall  = ~sel_n_s & sel_n_q;
    assign sel_rise  = sel_n_s & ~sel_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_fall) state_d = ST_SHIFT;
            ST_SHIFT: if (sel_rise) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_vld = (state_q == ST_CHECK) && (cnt_q == CNT_W'(FRAME_BITS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sel_n_q <= 1'b1;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_q  <= sclk_s;
            sel_n_q <= sel_n_s;
            if (state_q == ST_IDLE && sel_fall) begin
                cnt_q <= '0;
            end else if (state_q == ST_SHIFT && sclk_rise) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], dat_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frame_addr = shift_q[FRAME_BITS-1:DATA_W];
    assign frame_data = shift_q[DATA_W-1:0];
endmodule

// File: rtl/ser_ctl_lock.sv
module ser_ctl_lock #(
    parameter int LOCK_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q != CW'(LOCK_CYCLES))  cnt_q <= cnt_q + 1'b1;
    end

    assign busy = (cnt_q != CW'(LOCK_CYCLES));
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
    import ser_ctl_pkg::*;
#(
    parameter int LOCK_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_sel_n,
    input  logic              tx_on,
    output logic [GAIN_W-1:0] gain_out,
    output logic [PWR_W-1:0]  pwr_out,
    output logic              lock_busy,
    output logic              out_off
);
    logic              sclk_s, dat_s, sel_n_s, tx_s, tx_q;
    logic              tx_fall;
    logic              frame_vld, frame_ok, pg_hit, clr_hit;
    logic [ADDR_W-1:0] frame_addr;
    logic [DATA_W-1:0] frame_data;
    pg_word_t          shadow_q, active_q;

    ser_ctl_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_sel_n, ser_dat, tx_on}),
        .sync_out ({sclk_s, sel_n_s, dat_s, tx_s})
    );

    ser_ctl_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .dat_s      (dat_s),
        .sel_n_s    (sel_n_s),
        .frame_vld  (frame_vld),
        .frame_addr (frame_addr),
        .frame_data (frame_data)
    );

    ser_ctl_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (lock_busy)
    );

    assign frame_ok = frame_vld & ~lock_busy;
    assign pg_hit   = frame_ok && (frame_addr == ADDR_PG);
    assign clr_hit  = frame_ok && (frame_addr == ADDR_CLR);
    assign tx_fall  = tx_q & ~tx_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= 1'b0;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            tx_q <= tx_s;
            if (clr_hit)     shadow_q <= '0;
            else if (pg_hit) shadow_q <= pg_word_t'(frame_data);
            if (clr_hit)      active_q <= '0;
            else if (tx_fall) active_q <= shadow_q;
        end
    end

    assign gain_out = active_q.gain;
    assign pwr_out  = active_q.pwr;
    assign out_off  = ~tx_s;
endmodule

// File: rtl/ser_ctl_chk.sv
module ser_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_fall,
    input logic       clr_hit,
    input logic       lock_busy,
    input logic       out_off,
    input logic [7:0] shadow,
    input logic [7:0] active
);
    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_fall && !clr_hit) |=> $stable(active));

    // R6
    clear_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (active == 8'h00 && shadow == 8'h00));

    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_busy |=> !lock_busy);

    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy |=> $stable(shadow));

    // R8
    off_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_off) |-> tx_fall);
endmodule

bind ser_ctl_regs ser_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_fall   (tx_fall),
    .clr_hit   (clr_hit),
    .lock_busy (lock_busy),
    .out_off   (out_off),
    .shadow    (shadow_q),
    .active    (active_q)
);

// File: tb/ser_ctl_regs_bench.sv
module ser_ctl_regs_bench;
    localparam int LOCK = 300;
    localparam int NV   = 7;
    // {frame[11:0], expected {pwr,gain} after commit}
    localparam logic [19:0] VEC [NV] = '{
        {12'h02A, 8'h2A}, {12'h0C0, 8'hC0}, {12'h07F, 8'h7F},
        {12'h081, 8'h81}, {12'h355, 8'h81}, {12'h03F, 8'h3F},
        {12'hF00, 8'h3F}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel_n = 1'b1, tx_on = 1'b0;
    logic [5:0] gain_out;
    logic [1:0] pwr_out;
    logic lock_busy, out_off;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    ser_ctl_regs #(.LOCK_CYCLES(LOCK)) u_ser_ctl_regs (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_sel_n(ser_sel_n), .tx_on(tx_on), .gain_out(gain_out),
        .pwr_out(pwr_out), .lock_busy(lock_busy), .out_off(out_off)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        ser_sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic commit();
        tx_on = 1'b1;
        wait_clk(6);
        chk("R8 out_off low in transmit", {7'd0, out_off}, 8'h00);
        tx_on = 1'b0;
        wait_clk(6);
    endtask

    function automatic logic [7:0] act();
        return {pwr_out, gain_out};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        chk("R9 reset codes", act(), 8'h00);
        chk("R9 reset lock_busy", {7'd0, lock_busy}, 8'h01);
        chk("R8 out_off while tx low", {7'd0, out_off}, 8'h01);

        // R7: frame during lockout is dropped
        send(16'h0FF, 12);
        chk("R7 still locked", {7'd0, lock_busy}, 8'h01);
        commit();
        chk("R7 locked frame dropped", act(), 8'h00);
        for (int k = 0; k < 2 * LOCK && lock_busy; k++) wait_clk(1);
        chk("R7 lockout released", {7'd0, lock_busy}, 8'h00);
        commit();
        chk("R7 shadow untouched by locked frame", act(), 8'h00);

        // R1 R2 R5: vector table
        prev = 8'h00;
        for (int v = 0; v < NV; v++) begin
            send({4'h0, VEC[v][19:8]}, 12);
            chk("R2 held before commit", act(), prev);
            commit();
            chk("R1/R5 after commit", act(), VEC[v][7:0]);
            prev = VEC[v][7:0];
        end

        // R3: last of several writes wins
        send(16'h011, 12);
        send(16'h0A2, 12);
        chk("R2 held across two writes", act(), 8'h3F);
        commit();
        chk("R3 last write wins", act(), 8'hA2);

        // R4: 11-bit and 13-bit frames dropped
        send(16'h033, 11);
        commit();
        chk("R4 short frame dropped", act(), 8'hA2);
        send(16'h0033, 13);
        commit();
        chk("R4 long frame dropped", act(), 8'hA2);

        // R10: serial clock while deselected
        for (int p = 0; p < 5; p++) begin
            ser_dat = 1'b1;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        ser_dat = 1'b0;
        wait_clk(4);
        commit();
        chk("R10 idle clocks ignored", act(), 8'hA2);
        send(16'h045, 12);
        commit();
        chk("R10 next frame aligned", act(), 8'h45);

        // R6: clear acts without commit and empties shadow
        send(16'h02A, 12);
        chk("R2 held before clear", act(), 8'h45);
        send(16'h100, 12);
        chk("R6 active cleared at once", act(), 8'h00);
        commit();
        chk("R6 shadow cleared", act(), 8'h00);

        // R9: reset mid-run
        send(16'h0C7, 12);
        commit();
        chk("R1 before reset", act(), 8'hC7);
        rst_n = 1'b0;
        wait_clk(2);
        chk("R9 reset clears codes", act(), 8'h00);
        chk("R9 reset restarts lockout", {7'd0, lock_busy}, 8'h01);
        rst_n = 1'b1;
        wait_clk(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule